// File: doc/BRIEF.md
# Modular Doubling Sieve Engine

This block looks for exponents n at which an odd prime p divides k·2^n+1. The host computes the remainder of (2k+1) modulo p, which is the remainder at n=1, and passes it in together with p and an upper exponent bound. The engine then moves the remainder forward one exponent per clock using r → 2r−1 mod p. Each step is a left shift, a decrement, one compare against p and at most one subtraction, so no divider is needed. When the remainder reaches zero, the next value is p−1.

A run ends in one of four ways. The starting remainder is 1, which is a fixed point of the recurrence, so p can never divide. The remainder comes back to its starting value, so the sequence has closed a loop and its period is known. The loop closes after a zero remainder was seen, so the first factoring exponent and the period are both known. Or the exponent counter passes the bound. With f1 and the period known, p divides k·2^n+1 for every n = f1 + m·period with m ≥ 0.

Operands arrive on a valid/ready input. `in_ready` is high exactly when the engine is idle. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. While a run is in progress `in_ready` is low, so the source must hold its operands until the run ends. Any `in_valid` during that time is not accepted. Results are plain level outputs, marked by a one-cycle `done` pulse.

Top module: `msieve_engine`

## Requirements
- R1: `in_ready` is high exactly when `busy` is low. An accepted transfer raises `busy` on the next cycle. `in_valid` asserted while busy has no effect on the run or its results.
- R2: After reset: `busy`=0, `done`=0, `in_ready`=1, `status`=0, `f1_hit`=0, `f1`=0, `period`=0.
- R3: If the starting remainder is 1 and the bound is at least 1, the run ends after one busy cycle with `status`=2'b00 (never factors), `f1_hit`=0 and `period`=0.
- R4: If the remainder returns to its starting value at step n ≤ bound and no zero remainder was seen, the run ends with `status`=2'b10 and `period`=n. The run takes exactly `period` busy cycles. The remainder after step n is the one for exponent n+1.
- R5: If a zero remainder occurs, `f1` is the smallest exponent with remainder 0 and `f1_hit`=1. If the loop then closes, `status`=2'b11, `f1` ≤ `period`, and p divides k·2^(f1+m·period)+1 for every m ≥ 0.
- R6: If the loop has not closed by step n = bound, the run ends after bound+1 busy cycles with `status`=2'b01. `f1`/`f1_hit` still report any zero found at an exponent ≤ bound. A loop that closes at step n = bound is reported with R4/R5 status. A bound of 0 ends with 2'b01 after one cycle.
- R7: While idle, `status`, `f1_hit`, `f1` and `period` hold their values until the next accepted transfer.
- R8: `done` is high for exactly one cycle after the final step, with `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand transfer request |
| in_ready | output | 1 | High when idle, so a transfer can be taken |
| in_p | input | W | Odd prime modulus |
| in_r0 | input | W | Remainder at n=1, less than p |
| in_nmax | input | NW | Upper exponent bound |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 00 never, 01 bound, 10 loop closed, 11 loop closed after factor |
| f1_hit | output | 1 | A zero remainder was seen |
| f1 | output | NW | First factoring exponent |
| period | output | NW | Loop period |

## Verification
The bench builds the engine with W=16 and NW=16. With these widths it can run primes up to several thousand over their full period, and it can use exponent bounds far above any period it exercises. Small primes keep every run short enough to sweep many random primes and k values. Each run is checked against a model that evaluates k·2^n+1 mod p directly rather than through the recurrence. The bounds are chosen to land just below, exactly on, and above the period and the first factor exponent.

// File: rtl/msieve_pkg.sv
package msieve_pkg;
  typedef enum logic [1:0] {
    SV_NEVER  = 2'd0,
    SV_BOUND  = 2'd1,
    SV_CYCLE  = 2'd2,
    SV_FACTOR = 2'd3
  } sv_stat_e;
endpackage

// File: rtl/msieve_step.sv
// One step of r -> 2r-1 mod p; zero maps to p-1.
module msieve_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] r,
  input  logic [W-1:0] p,
  output logic [W-1:0] nxt
);
  logic [W:0] dbl;
  logic       wrap;

  always_comb begin
    dbl  = {r, 1'b0} - {{W{1'b0}}, 1'b1};
    wrap = (dbl >= {1'b0, p});
    if (r == '0)
      nxt = p - {{(W-1){1'b0}}, 1'b1};
    else if (wrap)
      nxt = dbl[W-1:0] - p;  // true result is below p, fits W bits
    else
      nxt = dbl[W-1:0];
  end
endmodule

// File: rtl/msieve_expcnt.sv
// Exponent counter, one bit wider than the bound so it can pass it.
module msieve_expcnt #(
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [NW-1:0] bound_in,
  output logic [NW-1:0] n_lo,
  output logic          past_bound
);
  logic [NW:0]   n_q;
  logic [NW-1:0] bound_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      bound_q <= '0;
    end else if (load) begin
      n_q     <= {{NW{1'b0}}, 1'b1};
      bound_q <= bound_in;
    end else if (adv) begin
      n_q <= n_q + 1'b1;
    end
  end

  assign n_lo       = n_q[NW-1:0];
  assign past_bound = (n_q > {1'b0, bound_q});
endmodule

// File: rtl/msieve_engine.sv
module msieve_engine #(
  parameter int W  = 32,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_p,
  input  logic [W-1:0]  in_r0,
  input  logic [NW-1:0] in_nmax,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic          f1_hit,
  output logic [NW-1:0] f1,
  output logic [NW-1:0] period
);
  import msieve_pkg::*;

  logic          take;
  logic [W-1:0]  p_q, r0_q, r_q, r_nxt;
  logic [NW-1:0] n_cur;
  logic          over;
  sv_stat_e      st_q;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  msieve_step #(.W(W)) u_step (
    .r   (r_q),
    .p   (p_q),
    .nxt (r_nxt)
  );

  msieve_expcnt #(.NW(NW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .adv        (busy),
    .bound_in   (in_nmax),
    .n_lo       (n_cur),
    .past_bound (over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      p_q    <= '0;
      r0_q   <= '0;
      r_q    <= '0;
      st_q   <= SV_NEVER;
      f1_hit <= 1'b0;
      f1     <= '0;
      period <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      p_q    <= in_p;
      r0_q   <= in_r0;
      r_q    <= in_r0;
      st_q   <= SV_NEVER;
      f1_hit <= 1'b0;
      f1     <= '0;
      period <= '0;
    end else if (busy) begin
      if (over) begin
        st_q <= SV_BOUND;
        busy <= 1'b0;
        done <= 1'b1;
      end else if (r_q == {{(W-1){1'b0}}, 1'b1}) begin
        // fixed point of 2r-1: p never divides
        st_q <= SV_NEVER;
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        if (r_q == '0 && !f1_hit) begin
          f1_hit <= 1'b1;
          f1     <= n_cur;
        end
        r_q <= r_nxt;
        if (r_nxt == r0_q) begin
          period <= n_cur;
          st_q   <= (f1_hit || r_q == '0) ? SV_FACTOR : SV_CYCLE;
          busy   <= 1'b0;
          done   <= 1'b1;
        end
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/msieve_chk.sv
module msieve_chk #(
  parameter int W  = 32,
  parameter int NW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_r0,
  input logic [NW-1:0] in_nmax,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status,
  input logic          f1_hit,
  input logic [NW-1:0] f1,
  input logic [NW-1:0] period
);
  assert_take_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  assert_unit_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_r0 == {{(W-1){1'b0}}, 1'b1} && in_nmax != '0)
      |=> ##1 (done && status == 2'b00));

  assert_cycle_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b10) |-> (!f1_hit && period != '0));

  assert_factor_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b11) |-> (f1_hit && f1 != '0 && f1 <= period));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_ready)) |=>
      ($stable(status) && $stable(f1_hit) && $stable(f1) && $stable(period)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind msieve_engine msieve_chk #(.W(W), .NW(NW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_r0    (in_r0),
  .in_nmax  (in_nmax),
  .busy     (busy),
  .done     (done),
  .status   (status),
  .f1_hit   (f1_hit),
  .f1       (f1),
  .period   (period)
);

// File: tb/sim_msieve_engine.sv
`timescale 1ns/1ps
module sim_msieve_engine;
  localparam int W  = 16;
  localparam int NW = 16;
  localparam int NV = 10;
  // {p, k, bound, expected status}; status 00 never, 01 bound, 10 loop, 11 loop after factor
  localparam logic [63:0] VEC [NV] = '{
    {16'd7,  16'd1, 16'd100, 16'd2},
    {16'd7,  16'd3, 16'd100, 16'd3},
    {16'd13, 16'd1, 16'd100, 16'd3},
    {16'd5,  16'd5, 16'd100, 16'd0},
    {16'd13, 16'd1, 16'd4,   16'd1},
    {16'd13, 16'd1, 16'd8,   16'd1},
    {16'd7,  16'd1, 16'd3,   16'd2},
    {16'd7,  16'd1, 16'd2,   16'd1},
    {16'd3,  16'd1, 16'd10,  16'd3},
    {16'd5,  16'd5, 16'd0,   16'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_p = '0;
  logic [W-1:0]  in_r0 = '0;
  logic [NW-1:0] in_nmax = '0;
  logic          busy, done, f1_hit;
  logic [1:0]    status;
  logic [NW-1:0] f1, period;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  msieve_engine #(.W(W), .NW(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_p(in_p), .in_r0(in_r0), .in_nmax(in_nmax), .busy(busy), .done(done),
    .status(status), .f1_hit(f1_hit), .f1(f1), .period(period)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int st);
    case (st)
      0: return "R3";
      1: return "R6";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic longint powmod2(input longint e, input longint p);
    longint v = 1 % p;
    for (longint i = 0; i < e; i++) v = (v * 2) % p;
    return v;
  endfunction

  function automatic bit is_prime(input int v);
    if (v < 3 || v % 2 == 0) return 0;
    for (int d = 3; d * d <= v; d += 2) if (v % d == 0) return 0;
    return 1;
  endfunction

  // Direct evaluation of k*2^n+1 mod p, independent of the recurrence.
  task automatic model(input longint p, input longint k, input longint nmax,
                       output int st, output int hit, output longint mf1,
                       output longint per, output longint lat);
    longint r0, pw, pw2, rem, nrem;
    st = 1; hit = 0; mf1 = 0; per = 0; lat = nmax + 1;
    r0 = (2 * k + 1) % p;
    if (nmax == 0) begin lat = 1; return; end
    if (r0 == 1) begin st = 0; lat = 1; return; end
    pw = 2 % p;
    for (longint n = 1; n <= nmax; n++) begin
      rem = ((k % p) * pw + 1) % p;
      if (rem == 0 && hit == 0) begin hit = 1; mf1 = n; end
      pw2  = (pw * 2) % p;
      nrem = ((k % p) * pw2 + 1) % p;
      if (nrem == r0) begin
        per = n; lat = n; st = hit ? 3 : 2;
        return;
      end
      pw = pw2;
    end
  endtask

  task automatic run_case(input longint p, input longint k, input longint nmax,
                          input int tbl_st, input bit interfere);
    int st, hit, exp_st;
    longint mf1, per, lat, cnt;
    logic [1:0] s_st; logic [NW-1:0] s_f1, s_per; logic s_hit;
    string tg;
    model(p, k, nmax, st, hit, mf1, per, lat);
    exp_st = (tbl_st >= 0) ? tbl_st : st;
    tg = tag_of(exp_st);
    @(negedge clk);
    in_p = W'(p); in_r0 = W'((2 * k + 1) % p); in_nmax = NW'(nmax); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "busy after transfer", busy, 1);
    chk("R1", "in_ready while busy", in_ready, 0);
    cnt = 0;
    while (!done && cnt < 100000) begin
      if (interfere && cnt == 2) begin
        in_valid = 1'b1; in_p = 16'd3; in_r0 = 16'd1; in_nmax = 16'd5;
      end
      if (interfere && cnt == 4) in_valid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(tg, "status", status, exp_st);
    chk(tg, "f1_hit", f1_hit, hit);
    chk(tg, "f1", f1, mf1);
    chk(tg, "period", period, per);
    chk(tg, "busy cycles", cnt, lat);
    chk("R8", "busy low with done", busy, 0);
    if (status == 2'b11 && f1_hit) begin
      chk("R5", "p | k*2^f1+1", (((k % p) * powmod2(f1, p)) + 1) % p, 0);
      chk("R5", "p | k*2^(f1+period)+1",
          (((k % p) * powmod2(longint'(f1) + period, p)) + 1) % p, 0);
      chk("R5", "p | k*2^(f1+2*period)+1",
          (((k % p) * powmod2(longint'(f1) + 2 * period, p)) + 1) % p, 0);
    end
    s_st = status; s_hit = f1_hit; s_f1 = f1; s_per = period;
    @(negedge clk);
    chk("R8", "done is one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R7", "status held", status, s_st);
    chk("R7", "f1_hit held", f1_hit, s_hit);
    chk("R7", "f1 held", f1, s_f1);
    chk("R7", "period held", period, s_per);
    chk("R1", "in_ready while idle", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "busy", busy, 0);
    chk("R2", "done", done, 0);
    chk("R2", "in_ready", in_ready, 1);
    chk("R2", "status", status, 0);
    chk("R2", "f1_hit", f1_hit, 0);
    chk("R2", "f1", f1, 0);
    chk("R2", "period", period, 0);

    for (int i = 0; i < NV; i++)
      run_case(longint'(VEC[i][63:48]), longint'(VEC[i][47:32]),
               longint'(VEC[i][31:16]), int'(VEC[i][15:0]), 1'b0);

    // R1: a transfer attempt mid-run with a never-factor operand set is ignored
    run_case(251, 2, 1000, -1, 1'b1);
    // larger prime, long loop
    run_case(4093, 7, 9000, -1, 1'b0);
    // R6: bound one below the period of p=13,k=1 (period 12), factor seen at 6
    run_case(13, 1, 11, 1, 1'b0);
    // R5: bound exactly at the period
    run_case(13, 1, 12, 3, 1'b0);

    for (int i = 0; i < 14; i++) begin
      int p;
      int k;
      do p = 3 + int'($urandom % 249); while (!is_prime(p));
      k = 1 + int'($urandom % 1000);
      run_case(p, k, 200, -1, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule